// File: doc/BRIEF.md
# Double-Buffered DAC Load Controller

This block is the digital front end of an 8-bit voltage-output converter. A host drives an 8-bit parallel bus with an active-low select, an active-low write strobe, an active-low load strobe and an active-low clear. All four strobes arrive asynchronously. Each one passes through a two-flop synchroniser and then an edge detector running on the system clock. The bus is first captured in an input register. A second register, the DAC register, then holds the code that drives the converter cells.

The path from the input register to the DAC register is chosen again on every write. The load strobe level is sampled when the write strobe rises. If the load strobe is low at that moment, the DAC register copies the input register at once. If it is high, the copy waits for the next falling edge of the load strobe, which lets several converters change together.

Each nibble of the DAC register drives a 4-to-15 thermometer decoder, so the block emits 30 thermometer lines in all. The 8-bit DAC register value is also exported. A power-on strobe, held low while the supply settles, forces both registers to zero.

Top module: `dac_load_ctrl`

## Requirements
- R1: While `por_ni` is low, the DAC register, the input register and the pending-load state are zero from the next clock. `rst_ni` low gives the same state asynchronously. In this state `dac_code_o`, `therm_o` and `proto_err_o` are all zero.
- R2: The input register follows `data_i` while the synchronised select and write strobes are both low. It holds its value from the detected write rising edge on, so changes on `data_i` after that edge never reach the DAC register.
- R3: A write is a write-strobe rising edge while the select is low. If the load strobe is low at that edge, the DAC register takes the input register value one clock after the detected edge.
- R4: If the load strobe is high at the write edge, the DAC register keeps its value. It then takes the captured input register value one clock after the next detected falling edge of the load strobe, and only once per write.
- R5: A write is a protocol error if the load strobe is still low and has not returned high since a deferred load completed. Such a write raises `proto_err_o` for exactly one clock, and that write still loads immediately.
- R6: While the synchronised clear is low, the DAC register is zero from the next clock. The clear takes priority over any simultaneous load.
- R7: A write-strobe rising edge while the select is high is ignored. The input register does not track, and the edge arms no deferred load.
- R8: `therm_o[14:0]` is the thermometer code of DAC bits [3:0], and `therm_o[29:15]` is the thermometer code of bits [7:4]. For a nibble value k, exactly the lowest k lines of its group are 1.
- R9: `dac_code_o` always equals the DAC register contents.
- R10: Each strobe goes through two synchroniser flops and an edge flop. A strobe change made between clock edges therefore affects the registers after the third following rising clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| por_ni | input | 1 | Power-on strobe, active low, synchronous level |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| wr_ni | input | 1 | Write strobe, active low, asynchronous |
| ldac_ni | input | 1 | Load strobe, active low, asynchronous |
| clr_ni | input | 1 | Clear, active low, asynchronous |
| data_i | input | 8 | Parallel data bus |
| dac_code_o | output | 8 | Current DAC register value |
| therm_o | output | 30 | Thermometer lines: [14:0] for the low nibble, [29:15] for the high nibble |
| proto_err_o | output | 1 | One-clock pulse on a write that breaks the load-strobe protocol |

## Verification
A strobe edge reaches the registers after three rising clock edges: two synchroniser flops, then the register update. The DAC code and the thermometer lines follow the register with no further delay. The power-on strobe is not synchronised, so it acts after one edge. The bench drives every input one time unit after a rising edge and samples one time unit after the edge on which a result is due. For latency checks it also samples after the edge before, to confirm that the result has not appeared yet. The error pulse is sampled after the third edge, where it must be high, and again after the fourth, where it must be low again.

// File: rtl/dac_load_pkg.sv
package dac_load_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NIB_W  = 4;

  // strobe index in the synchroniser vector
  localparam int unsigned IDX_CS   = 0;
  localparam int unsigned IDX_WR   = 1;
  localparam int unsigned IDX_LDAC = 2;
  localparam int unsigned IDX_CLR  = 3;
  localparam int unsigned N_STROBE = 4;

  typedef enum logic [1:0] {
    UPD_NONE = 2'd0,
    UPD_AUTO = 2'd1,
    UPD_DEFER = 2'd2,
    UPD_CLEAR = 2'd3
  } upd_e;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q <= {STAGES{IDLE[b]}};
        prev_q  <= IDLE[b];
      end else begin
        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
        prev_q  <= chain_q[STAGES-1];
      end
    end

    assign level_o[b] = chain_q[STAGES-1];
    assign rise_o[b]  = chain_q[STAGES-1] & ~prev_q;
    assign fall_o[b]  = ~chain_q[STAGES-1] & prev_q;

    assert_edge_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rise_o[b] && fall_o[b]));
    assert_edge_follows_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[b] |=> !rise_o[b]);
  end
endmodule

// File: rtl/therm_dec.sv
module therm_dec #(
  parameter int unsigned IN_W = 4,
  localparam int unsigned OUT_W = (1 << IN_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] therm_o
);
  for (genvar i = 0; i < OUT_W; i++) begin : g_line
    assign therm_o[i] = (val_i > IN_W'(i));
  end

  assert_therm_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(therm_o) == int'(val_i));
  assert_therm_shape_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((therm_o + OUT_W'(1)) & therm_o) == '0);
endmodule

// File: rtl/load_core.sv
module load_core
  import dac_load_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         por_ni,
  input  logic         cs_lvl_i,
  input  logic         wr_lvl_i,
  input  logic         wr_rise_i,
  input  logic         ldac_lvl_i,
  input  logic         ldac_rise_i,
  input  logic         ldac_fall_i,
  input  logic         clr_lvl_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] dac_o,
  output logic         err_o
);
  logic [W-1:0] in_q, dac_q;
  logic         pend_q, done_q, err_q;
  logic         accept;
  upd_e         upd;

  assign accept = wr_rise_i & ~cs_lvl_i;

  always_comb begin
    upd = UPD_NONE;
    if (!clr_lvl_i)                  upd = UPD_CLEAR;
    else if (accept && !ldac_lvl_i)  upd = UPD_AUTO;
    else if (ldac_fall_i && pend_q)  upd = UPD_DEFER;
  end

  // input register: transparent while selected and strobe low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          in_q <= '0;
    else if (!por_ni)                     in_q <= '0;
    else if (!cs_lvl_i && !wr_lvl_i)      in_q <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_q  <= '0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (!por_ni) begin
      dac_q  <= '0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= accept && !ldac_lvl_i && done_q;
      unique case (upd)
        UPD_CLEAR: dac_q <= '0;
        UPD_AUTO,
        UPD_DEFER: dac_q <= in_q;
        default:   dac_q <= dac_q;
      endcase
      // pending flag: armed by a write with load strobe high
      if (accept)
        pend_q <= ldac_lvl_i;
      else if (ldac_fall_i)
        pend_q <= 1'b0;
      if (ldac_rise_i)
        done_q <= 1'b0;
      else if (ldac_fall_i && pend_q)
        done_q <= 1'b1;
    end
  end

  assign dac_o = dac_q;
  assign err_o = err_q;

  assert_por_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_ni |=> (dac_q == '0 && in_q == '0 && !pend_q));
  assert_auto_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_ni && clr_lvl_i && accept && !ldac_lvl_i) |=> dac_q == $past(in_q));
  assert_defer_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_ni && clr_lvl_i && ldac_fall_i && pend_q) |=> dac_q == $past(in_q));
  assert_dac_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_q != $past(dac_q)) |-> $past(upd != UPD_NONE || !por_ni));
  assert_err_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> !err_q);
  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_ni && !clr_lvl_i) |=> dac_q == '0);
  assert_cs_ignore_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_ni && wr_rise_i && cs_lvl_i && !pend_q) |=> !pend_q);
endmodule

// File: rtl/dac_load_ctrl.sv
module dac_load_ctrl
  import dac_load_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NW = NIB_W,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NIBS = DW / NW,
  localparam int unsigned TW = (1 << NW) - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               por_ni,
  input  logic               cs_ni,
  input  logic               wr_ni,
  input  logic               ldac_ni,
  input  logic               clr_ni,
  input  logic [DW-1:0]      data_i,
  output logic [DW-1:0]      dac_code_o,
  output logic [NIBS*TW-1:0] therm_o,
  output logic               proto_err_o
);
  logic [N_STROBE-1:0] async_v, lvl, rise, fall;
  logic                unused_edges;

  assign async_v[IDX_CS]   = cs_ni;
  assign async_v[IDX_WR]   = wr_ni;
  assign async_v[IDX_LDAC] = ldac_ni;
  assign async_v[IDX_CLR]  = clr_ni;

  strobe_sync #(.WIDTH(N_STROBE), .STAGES(SYNC_STAGES), .IDLE('1)) u_sync (
    .clk_i, .rst_ni, .async_i(async_v), .level_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  assign unused_edges = ^{rise[IDX_CS], fall[IDX_CS], fall[IDX_WR],
                          rise[IDX_CLR], fall[IDX_CLR]};

  load_core #(.W(DW)) u_core (
    .clk_i, .rst_ni, .por_ni,
    .cs_lvl_i   (lvl[IDX_CS]),
    .wr_lvl_i   (lvl[IDX_WR]),
    .wr_rise_i  (rise[IDX_WR]),
    .ldac_lvl_i (lvl[IDX_LDAC]),
    .ldac_rise_i(rise[IDX_LDAC]),
    .ldac_fall_i(fall[IDX_LDAC]),
    .clr_lvl_i  (lvl[IDX_CLR]),
    .data_i,
    .dac_o      (dac_code_o),
    .err_o      (proto_err_o)
  );

  for (genvar n = 0; n < NIBS; n++) begin : g_nib
    therm_dec #(.IN_W(NW)) u_dec (
      .clk_i, .rst_ni,
      .val_i  (dac_code_o[n*NW +: NW]),
      .therm_o(therm_o[n*TW +: TW])
    );
  end

  assert_code_port_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_ni |=> dac_code_o == '0);
endmodule

// File: tb/dac_load_ctrl_test.sv
module dac_load_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0, por_ni = 1'b1;
  logic        cs_ni = 1'b1, wr_ni = 1'b1, ldac_ni = 1'b1, clr_ni = 1'b1;
  logic [7:0]  data_i = '0;
  logic [7:0]  dac_code_o;
  logic [29:0] therm_o;
  logic        proto_err_o;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] exp_dac = '0;
  logic [7:0] early_dac;
  logic       err_at3, err_at4;

  always #5 clk = ~clk;

  dac_load_ctrl uut (.clk_i(clk), .rst_ni, .por_ni, .cs_ni, .wr_ni, .ldac_ni,
                     .clr_ni, .data_i, .dac_code_o, .therm_o, .proto_err_o);

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [29:0] therm_ref(input logic [7:0] v);
    logic [29:0] t = '0;
    for (int i = 0; i < 15; i++) begin
      t[i]      = (i < int'(v[3:0]));
      t[15 + i] = (i < int'(v[7:4]));
    end
    return t;
  endfunction

  // a write: select, strobe low, data, strobe high; samples at +2, +3, +4 edges
  task automatic do_write(input logic [7:0] d, input logic ld);
    ldac_ni = ld;
    tick(4);
    cs_ni = 1'b0; wr_ni = 1'b0; data_i = d;
    tick(4);
    wr_ni = 1'b1;
    tick(2); early_dac = dac_code_o;
    tick(1); err_at3 = proto_err_o;
    tick(1); err_at4 = proto_err_o;
    cs_ni = 1'b1;
    tick(3);
  endtask

  task automatic t_reset();
    check("R1 reset dac", dac_code_o, 0);
    check("R1 reset therm", therm_o, 0);
    check("R1 reset err", proto_err_o, 0);
  endtask

  task automatic t_auto();
    do_write(8'hA5, 1'b0);
    check("R10 auto not before third edge", early_dac, exp_dac);
    exp_dac = 8'hA5;
    check("R3 auto load", dac_code_o, exp_dac);
    check("R9 code port", dac_code_o, 8'hA5);
    check("R8 therm A5", therm_o, therm_ref(8'hA5));
    check("R5 no err on plain auto", err_at3, 0);
  endtask

  task automatic t_defer();
    do_write(8'h3C, 1'b1);
    check("R4 deferred hold", dac_code_o, exp_dac);
    data_i = 8'hFF;
    tick(4);
    ldac_ni = 1'b0;
    tick(2);
    check("R10 defer not before third edge", dac_code_o, exp_dac);
    tick(1);
    exp_dac = 8'h3C;
    check("R2 held value loaded", dac_code_o, exp_dac);
    // write while load strobe still low after deferred load
    do_write(8'h81, 1'b0);
    check("R5 err pulse high", err_at3, 1);
    check("R5 err pulse one clock", err_at4, 0);
    exp_dac = 8'h81;
    check("R5 write still loads", dac_code_o, exp_dac);
    ldac_ni = 1'b1;
    tick(4);
    ldac_ni = 1'b0;
    tick(4);
    check("R4 one load per write", dac_code_o, exp_dac);
    ldac_ni = 1'b1;
    tick(4);
  endtask

  task automatic t_cs_ignore();
    ldac_ni = 1'b1;
    data_i = 8'h55;
    tick(4);
    wr_ni = 1'b0;
    tick(4);
    wr_ni = 1'b1;
    tick(4);
    check("R7 deselected write no change", dac_code_o, exp_dac);
    ldac_ni = 1'b0;
    tick(4);
    check("R7 deselected write arms nothing", dac_code_o, exp_dac);
    ldac_ni = 1'b1;
    tick(4);
  endtask

  task automatic t_clear();
    clr_ni = 1'b0;
    tick(2);
    check("R10 clear not before third edge", dac_code_o, exp_dac);
    tick(1);
    exp_dac = '0;
    check("R6 clear zero", dac_code_o, 0);
    do_write(8'h77, 1'b0);
    check("R6 clear beats load", dac_code_o, 0);
    check("R6 therm zero", therm_o, 0);
    clr_ni = 1'b1;
    tick(4);
    check("R6 stays zero after release", dac_code_o, 0);
    ldac_ni = 1'b1;
    tick(4);
  endtask

  task automatic t_therm();
    logic [7:0] vals [5] = '{8'h00, 8'hF0, 8'h0F, 8'hFF, 8'h18};
    foreach (vals[k]) begin
      do_write(vals[k], 1'b0);
      exp_dac = vals[k];
      check("R8 therm pattern", therm_o, therm_ref(vals[k]));
      check("R9 code pattern", dac_code_o, exp_dac);
    end
    ldac_ni = 1'b1;
    tick(4);
  endtask

  task automatic t_random();
    for (int k = 0; k < 16; k++) begin
      logic [7:0] d = 8'($urandom);
      logic mode = 1'($urandom);
      if (!mode) begin
        do_write(d, 1'b0);
        exp_dac = d;
        check("R3 random auto", dac_code_o, exp_dac);
      end else begin
        do_write(d, 1'b1);
        check("R4 random hold", dac_code_o, exp_dac);
        ldac_ni = 1'b0;
        tick(3);
        exp_dac = d;
        check("R4 random deferred", dac_code_o, exp_dac);
        ldac_ni = 1'b1;
        tick(3);
      end
    end
    ldac_ni = 1'b1;
    tick(4);
  endtask

  task automatic t_por();
    do_write(8'h99, 1'b0);
    check("R3 pre por load", dac_code_o, 8'h99);
    por_ni = 1'b0;
    tick(1);
    exp_dac = '0;
    check("R1 por dac zero", dac_code_o, 0);
    check("R1 por therm zero", therm_o, 0);
    por_ni = 1'b1;
    ldac_ni = 1'b1;
    tick(4);
    ldac_ni = 1'b0;
    tick(4);
    check("R1 por input reg zero", dac_code_o, 0);
    ldac_ni = 1'b1;
    tick(4);
  endtask

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(2);
    t_reset();
    t_auto();
    t_defer();
    t_cs_ignore();
    t_clear();
    t_therm();
    t_random();
    t_por();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule